// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block watches the data line on behalf of an I2C master that shares the bus with other masters. At every bit-sample strobe (the point where SCL has risen and the line is read), it compares the value the master put on SDA with the value seen on the wire. If the master released SDA (a 1) but the wire reads 0, another device has overruled it and arbitration is lost. Only the SDA value at the strobe is compared.

Loss is handled differently in the two master modes. As a transmitter, the master may lose on any of the eight data bits. It then asks the mode controller to fall back to slave-receiver operation, but it keeps the clock generator running until the acknowledge slot of the current byte has been sampled. After that, the clock stops. As a receiver, the master drives SDA only in the acknowledge slot. Loss can therefore only happen when it sends a not-acknowledge and another device pulls the line low. In that case the clock stops at once.

The loss flag stays set until software clears it, and the interrupt output follows the flag. The inputs are plain control pins sampled on the clock, with no handshake. The one-cycle request to the mode controller is a pulse, so it carries no back-pressure.

Top module: `i2c_arb_monitor`

## Requirements
- R1: In master-transmitter mode (mode code 2'b01), a strobe on a data bit (bit index 0 to 7) with the driven bit 1 and the bus bit 0 sets arb_lost_o on that clock edge.
- R2: A driven 0 never causes a loss, whatever the bus shows. A driven 1 read back as 1 never causes a loss.
- R3: In master-transmitter mode the acknowledge slot (bit index 8) is not compared, because the addressed receiver drives it.
- R4: After a transmitter loss, clk_run_o stays 1 through the remaining data bits. It drops on the edge that takes the strobe at bit index 8 and then stays 0.
- R5: In master-receiver mode (mode code 2'b10), a strobe at bit index 8 with the driven bit 1 and the bus bit 0 sets arb_lost_o and drops clk_run_o on the same edge. A driven 0 (acknowledge) in that slot does not.
- R6: In master-receiver mode, strobes on bit indices 0 to 7 never cause a loss.
- R7: to_slave_o is a single-cycle pulse, high for exactly the cycle after the edge on which arb_lost_o rises.
- R8: arb_lost_o and irq_o stay set until flag_clr_i is asserted. A clear returns arb_lost_o and irq_o to 0 and clk_run_o to 1 on the next edge.
- R9: In the non-master mode codes 2'b00 and 2'b11, no comparison is made.
- R10: After reset, arb_lost_o, to_slave_o and irq_o are 0 and clk_run_o is 1.
- R11: Without sample_stb_i, no comparison is made, even if the driven and bus bits disagree.
- R12: While arb_lost_o is set, further mismatches do not produce another to_slave_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Bus role: 00 idle, 01 master transmitter, 10 master receiver, 11 slave receiver |
| sda_drive_i | input | 1 | Bit the master is putting on SDA (1 = released) |
| sda_bus_i | input | 1 | SDA as sampled from the wire |
| bit_idx_i | input | BIT_W | Position in the byte: 0 to 7 data, 8 acknowledge |
| sample_stb_i | input | 1 | One-cycle strobe at the SCL rising-edge sample |
| flag_clr_i | input | 1 | Software clear of the loss flag |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| to_slave_o | output | 1 | One-cycle request to switch to slave receiver |
| clk_run_o | output | 1 | Clock generator may keep producing pulses |
| irq_o | output | 1 | Serial interrupt request raised by the loss |

## Verification
The bench targets four corner cases.

- The acknowledge slot in transmitter mode: a design that compared it would report a false loss every time a slave acknowledges.
- The data bits in receiver mode: a design that compared them would lose arbitration on ordinary received data.
- The clock after a transmitter loss: it is followed bit by bit up to the acknowledge strobe, because a design that stopped early would cut a byte short, and one that never stopped would clock into the next byte.
- Stickiness, the single request pulse and the driven-zero case: a broken design would drop the flag, repeat the switch request, or flag a loss on a driven zero.

// File: rtl/arb_mon_pkg.sv
package arb_mon_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_MTX  = 2'b01,
    MODE_MRX  = 2'b10,
    MODE_SRX  = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_DRAIN = 2'b01,
    ST_HALT  = 2'b10
  } arb_state_e;

endpackage

// File: rtl/arb_mon_cmp.sv
module arb_mon_cmp
  import arb_mon_pkg::*;
#(
  parameter int BIT_W   = 4,
  parameter int ACK_IDX = 8
) (
  input  logic [1:0]       mode_i,
  input  logic             sda_drive_i,
  input  logic             sda_bus_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             sample_stb_i,
  input  logic             armed_i,
  output logic             tx_loss_o,
  output logic             rx_loss_o,
  output logic             ack_strobe_o
);

  localparam logic [BIT_W-1:0] ACK_POS = BIT_W'(ACK_IDX);

  bus_mode_e mode;
  logic      overruled;
  logic      in_data;
  logic      in_ack;

  always_comb begin
    mode         = bus_mode_e'(mode_i);
    // released line read back low: someone else is driving
    overruled    = sample_stb_i && sda_drive_i && !sda_bus_i;
    in_data      = bit_idx_i < ACK_POS;
    in_ack       = bit_idx_i == ACK_POS;
    ack_strobe_o = sample_stb_i && in_ack;
    tx_loss_o    = armed_i && overruled && in_data && (mode == MODE_MTX);
    rx_loss_o    = armed_i && overruled && in_ack  && (mode == MODE_MRX);
  end

endmodule

// File: rtl/arb_mon_fsm.sv
module arb_mon_fsm
  import arb_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_loss_i,
  input  logic rx_loss_i,
  input  logic ack_strobe_i,
  input  logic flag_clr_i,
  output logic armed_o,
  output logic lost_o,
  output logic clk_run_o
);

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (rx_loss_i)      state_d = ST_HALT;
        else if (tx_loss_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (flag_clr_i)        state_d = ST_RUN;
        else if (ack_strobe_i) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (flag_clr_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    armed_o   = state_q == ST_RUN;
    lost_o    = state_q != ST_RUN;
    clk_run_o = state_q != ST_HALT;
  end

endmodule

// File: rtl/arb_mon_req.sv
module arb_mon_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_loss_i,
  input  logic rx_loss_i,
  output logic to_slave_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_slave_o <= 1'b0;
    else        to_slave_o <= tx_loss_i || rx_loss_i;
  end

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int BIT_W   = 4,
  parameter int ACK_IDX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             sda_drive_i,
  input  logic             sda_bus_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             sample_stb_i,
  input  logic             flag_clr_i,
  output logic             arb_lost_o,
  output logic             to_slave_o,
  output logic             clk_run_o,
  output logic             irq_o
);

  logic tx_loss, rx_loss, ack_strobe, armed;

  arb_mon_cmp #(.BIT_W(BIT_W), .ACK_IDX(ACK_IDX)) u_cmp (
    .mode_i       (mode_i),
    .sda_drive_i  (sda_drive_i),
    .sda_bus_i    (sda_bus_i),
    .bit_idx_i    (bit_idx_i),
    .sample_stb_i (sample_stb_i),
    .armed_i      (armed),
    .tx_loss_o    (tx_loss),
    .rx_loss_o    (rx_loss),
    .ack_strobe_o (ack_strobe)
  );

  arb_mon_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_loss_i    (tx_loss),
    .rx_loss_i    (rx_loss),
    .ack_strobe_i (ack_strobe),
    .flag_clr_i   (flag_clr_i),
    .armed_o      (armed),
    .lost_o       (arb_lost_o),
    .clk_run_o    (clk_run_o)
  );

  arb_mon_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_loss_i  (tx_loss),
    .rx_loss_i  (rx_loss),
    .to_slave_o (to_slave_o)
  );

  assign irq_o = arb_lost_o;

endmodule

// File: rtl/arb_mon_chk.sv
module arb_mon_chk #(
  parameter int BIT_W   = 4,
  parameter int ACK_IDX = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             sda_drive_i,
  input logic             sda_bus_i,
  input logic [BIT_W-1:0] bit_idx_i,
  input logic             sample_stb_i,
  input logic             flag_clr_i,
  input logic             arb_lost_o,
  input logic             to_slave_o,
  input logic             clk_run_o,
  input logic             irq_o
);

  localparam logic [BIT_W-1:0] ACK_POS = BIT_W'(ACK_IDX);

  logic mismatch;
  assign mismatch = sample_stb_i && sda_drive_i && !sda_bus_i;

  a_r1_tx_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && mode_i == 2'b01 && mismatch && bit_idx_i < ACK_POS) |=> arb_lost_o);

  a_r2_zero_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && !sda_drive_i) |=> !arb_lost_o);

  a_r3_tx_ack_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && mode_i == 2'b01 && bit_idx_i == ACK_POS) |=> !arb_lost_o);

  a_r4_drain_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o && clk_run_o && !(sample_stb_i && bit_idx_i == ACK_POS)) |=> clk_run_o);

  a_r5_rx_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && mode_i == 2'b10 && mismatch && bit_idx_i == ACK_POS)
      |=> (arb_lost_o && !clk_run_o));

  a_r6_rx_data_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && mode_i == 2'b10 && bit_idx_i < ACK_POS) |=> !arb_lost_o);

  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost_o) |-> to_slave_o);

  a_r7_pulse_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    to_slave_o |-> arb_lost_o);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o && !flag_clr_i) |=> arb_lost_o);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == arb_lost_o);

  a_r9_idle_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && (mode_i == 2'b00 || mode_i == 2'b11)) |=> !arb_lost_o);

  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_lost_o && !sample_stb_i) |=> !arb_lost_o);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o && !flag_clr_i) |=> !to_slave_o);

endmodule

bind i2c_arb_monitor arb_mon_chk #(.BIT_W(BIT_W), .ACK_IDX(ACK_IDX)) u_chk (.*);

// File: tb/i2c_arb_monitor_test.sv
`timescale 1ns/1ps
module i2c_arb_monitor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       sda_drive_i = 1'b1;
  logic       sda_bus_i = 1'b1;
  logic [3:0] bit_idx_i = 4'd0;
  logic       sample_stb_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       arb_lost_o, to_slave_o, clk_run_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_arb_monitor uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sda_drive_i(sda_drive_i),
    .sda_bus_i(sda_bus_i), .bit_idx_i(bit_idx_i), .sample_stb_i(sample_stb_i),
    .flag_clr_i(flag_clr_i), .arb_lost_o(arb_lost_o), .to_slave_o(to_slave_o),
    .clk_run_o(clk_run_o), .irq_o(irq_o)
  );

  // {req[3:0], mode[1:0], drive, bus, bit[3:0], exp_lost, exp_run}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1,  2'b01, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1},  // R1 first data bit
    {4'd1,  2'b01, 1'b1, 1'b0, 4'd7, 1'b1, 1'b1},  // R1 last data bit
    {4'd2,  2'b01, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1},  // R2 driven 0 matches
    {4'd2,  2'b01, 1'b1, 1'b1, 4'd5, 1'b0, 1'b1},  // R2 driven 1 read 1
    {4'd2,  2'b01, 1'b0, 1'b1, 4'd2, 1'b0, 1'b1},  // R2 driven 0 read 1
    {4'd3,  2'b01, 1'b1, 1'b0, 4'd8, 1'b0, 1'b1},  // R3 ack from slave
    {4'd5,  2'b10, 1'b1, 1'b0, 4'd8, 1'b1, 1'b0},  // R5 nack overruled
    {4'd5,  2'b10, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1},  // R5 own ack
    {4'd6,  2'b10, 1'b1, 1'b0, 4'd4, 1'b0, 1'b1},  // R6 received data
    {4'd6,  2'b10, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1},  // R6 received data
    {4'd9,  2'b00, 1'b1, 1'b0, 4'd3, 1'b0, 1'b1},  // R9 idle
    {4'd9,  2'b11, 1'b1, 1'b0, 4'd8, 1'b0, 1'b1}   // R9 slave receiver
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] m, input logic d, input logic b, input logic [3:0] i);
    @(negedge clk);
    mode_i = m; sda_drive_i = d; sda_bus_i = b; bit_idx_i = i; sample_stb_i = 1'b1;
    @(negedge clk);
    sample_stb_i = 1'b0; sda_drive_i = 1'b1; sda_bus_i = 1'b1;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "lost", arb_lost_o, 1'b0);
    check("R10", "to_slave", to_slave_o, 1'b0);
    check("R10", "clk_run", clk_run_o, 1'b1);
    check("R10", "irq", irq_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][13:10]);
      clear_flag();
      strobe(VEC[v][9:8], VEC[v][7], VEC[v][6], VEC[v][5:2]);
      check(tag, $sformatf("vec%0d lost", v), arb_lost_o, VEC[v][1]);
      check(tag, $sformatf("vec%0d clk_run", v), clk_run_o, VEC[v][0]);
    end

    // R11 mismatch without strobe
    clear_flag();
    @(negedge clk);
    mode_i = 2'b01; sda_drive_i = 1'b1; sda_bus_i = 1'b0; bit_idx_i = 4'd2;
    @(negedge clk);
    @(negedge clk);
    sda_bus_i = 1'b1;
    check("R11", "lost without strobe", arb_lost_o, 1'b0);

    // R4 and R7: transmitter loss at bit 2, drain to ack
    strobe(2'b01, 1'b1, 1'b0, 4'd2);
    check("R7", "to_slave pulse", to_slave_o, 1'b1);
    check("R1", "lost at bit 2", arb_lost_o, 1'b1);
    check("R8", "irq with flag", irq_o, 1'b1);
    @(negedge clk);
    check("R7", "to_slave one cycle", to_slave_o, 1'b0);
    for (int b = 3; b < 8; b++) begin
      strobe(2'b11, 1'b1, 1'b1, 4'(b));
      check("R4", $sformatf("clk_run at bit %0d", b), clk_run_o, 1'b1);
    end
    // R12 further mismatch while lost gives no new pulse
    strobe(2'b01, 1'b1, 1'b0, 4'd7);
    check("R12", "no second pulse", to_slave_o, 1'b0);
    strobe(2'b11, 1'b1, 1'b0, 4'd8);
    check("R4", "clk_run after ack", clk_run_o, 1'b0);
    repeat (5) @(negedge clk);
    check("R4", "clock stays stopped", clk_run_o, 1'b0);
    check("R8", "flag sticky", arb_lost_o, 1'b1);

    // R8 clear
    clear_flag();
    check("R8", "lost cleared", arb_lost_o, 1'b0);
    check("R8", "irq cleared", irq_o, 1'b0);
    check("R8", "clk_run restored", clk_run_o, 1'b1);

    // R5 and R7: receiver nack loss stops at once
    strobe(2'b10, 1'b1, 1'b0, 4'd8);
    check("R5", "rx lost", arb_lost_o, 1'b1);
    check("R5", "rx clock stop", clk_run_o, 1'b0);
    check("R7", "rx to_slave pulse", to_slave_o, 1'b1);
    clear_flag();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule